// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block powers gated domains up and down in a fixed, timed order. For every domain it drives:

- a top-level sleep control for the power switch;
- a field of memory power-down bits;
- an isolation control;
- a domain reset;
- a clock enable.

Software writes a one-cycle request that names a domain and a direction. It then polls `busy_o` and the per-domain `off_o` status until the sequence has finished. Each gap between steps comes from one shared down-counter. The gap lengths are set in microseconds and scaled by a clock-rate parameter.

Domains are described per bit by three parameter masks:

- whether the domain has top-level sleep and isolation controls, or memory fields only;
- whether it has a clock to gate;
- whether it comes out of reset already powered. A domain that is powered at reset is treated as always-on.

A shutdown strobe walks every domain in ascending index order. It powers off each switchable domain that is still on, one domain at a time.

Top module: `pwr_switch_seq`

## Requirements
- R1: After reset, a domain flagged as powered at reset has sleep, isolation and all memory bits at 0 and its clock enable at 1 when it has a clock. Every other domain has its memory bits all 1, and sleep and isolation at 1 when it has top-level controls. Its clock enable is 0. All domain resets are 0 and `busy_o` is 0.
- R2: A power-off request accepted at clock edge k produces these changes:
  - sleep goes to 1 at edge k+1;
  - the memory field goes to all ones at edge k+1+S;
  - isolation goes to 1 at edge k+1+2S;
  - the clock enable goes to 0 at edge k+1+2S+L, when the domain has a clock.
  Here S = SHORT_US*CYC_PER_US and L = LONG_US*CYC_PER_US.
- R3: A power-on request accepted at clock edge k produces these changes:
  - sleep goes to 0 at edge k+1;
  - the memory field goes to 0 at edge k+1+S;
  - the domain reset goes to 1 at edge k+1+2S;
  - isolation goes to 0 at edge k+2+2S;
  - the domain reset goes to 0 at edge k+3+2S;
  - the clock enable goes to 1 at edge k+4+2S, when the domain has a clock.
- R4: A domain with memory fields only keeps sleep and isolation at 0 through its sequences. Its memory-field change still comes S cycles after acceptance plus one, and its reset pulse still comes 2S cycles after acceptance plus one.
- R5: `off_o[d]` equals the sleep bit for a domain with top-level controls. For a memory-only domain it is 1 exactly when all of its memory bits are 1.
- R6: Requests are taken only while `busy_o` is 0. `busy_o` is 1 from the edge of acceptance until the cycle after the last step. No output changes while it is 0, and a request made while busy has no effect. Requests that name an index at or above N_DOM are also dropped.
- R7: A request for the state a domain already has holds `busy_o` high for one cycle and changes no output.
- R8: A power-off request to a domain that was powered at reset is treated like R7 and leaves the domain on.
- R9: A shutdown strobe taken in idle powers off, in ascending index order, each domain with top-level controls whose `off_o` is 0. For a domain at index 0 the off sequence begins one cycle after the strobe. Each later domain's sleep step follows the previous domain's last step by three cycles. Domains already off, and memory-only domains, are left unchanged.

Port widths below are for the default parameters: N_DOM = 3 and MEM_W = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | One-cycle request strobe |
| req_dom_i | input | DOM_W (2) | Index of the requested domain |
| req_on_i | input | 1 | 1 = power on, 0 = power off |
| shutdown_i | input | 1 | One-cycle strobe: power off all switchable domains |
| busy_o | output | 1 | Sequence in progress |
| off_o | output | N_DOM (3) | Per-domain powered-off status |
| sleep_o | output | N_DOM (3) | Per-domain power-switch sleep control, 1 = asleep |
| iso_o | output | N_DOM (3) | Per-domain isolation control, 1 = isolated |
| mem_pd_o | output | N_DOM*MEM_W (12) | Memory power-down bits; domain d owns bits [d*MEM_W +: MEM_W] |
| rst_o | output | N_DOM (3) | Per-domain reset, 1 = held in reset |
| clk_en_o | output | N_DOM (3) | Per-domain clock enable |

## Verification
Every step lands a fixed number of edges after the edge that accepts a request:

- the sleep change at one edge;
- the memory field at one edge plus S;
- the reset or isolation change at one edge plus 2S;
- each later on-step one further edge apart;
- on power-off, clock gating a further L edges after isolation.

The bench counts edges from the acceptance edge and samples on the following falling edge. At each boundary it checks the output both one edge before and at the edge where it must change, so a step that comes early or late is caught. During shutdown the bench checks, at the exact edges, that the second domain's sleep control stays clear until three cycles after the first domain's clock is gated.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SCAN,
    ST_TOP,
    ST_WMEM,
    ST_WGATE,
    ST_WCLK,
    ST_ISOCLR,
    ST_RSTREL,
    ST_CLKON,
    ST_FIN
  } seq_state_e;

  // One field write per step; val is the value written (1 = sleep/down/iso/reset/enable)
  typedef struct packed {
    logic sleep_wr;
    logic mem_wr;
    logic iso_wr;
    logic rst_wr;
    logic clk_wr;
    logic val;
  } dom_op_t;

endpackage

// File: rtl/pwr_wait_ctr.sv
module pwr_wait_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R2

endmodule

// File: rtl/pwr_dom_slice.sv
module pwr_dom_slice
  import pwr_seq_pkg::*;
#(
  parameter int MEM_W   = 4,
  parameter bit HAS_TOP = 1'b1,
  parameter bit HAS_CLK = 1'b1,
  parameter bit BOOT_ON = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  dom_op_t          op,
  output logic             sleep_o,
  output logic             iso_o,
  output logic             rst_o,
  output logic             clk_en_o,
  output logic             off_o,
  output logic [MEM_W-1:0] mem_o
);

  localparam bit         RST_TOP = HAS_TOP & ~BOOT_ON;
  localparam bit         RST_CLK = HAS_CLK & BOOT_ON;
  localparam [MEM_W-1:0] RST_MEM = {MEM_W{~BOOT_ON}};

  logic sleep_q, iso_q, rst_q, clk_q;
  logic [MEM_W-1:0] mem_q;
  logic sleep_en, iso_en, rst_en, clk_en, mem_en;

  // Clock enables per field
  always_comb begin
    sleep_en = sel & op.sleep_wr & HAS_TOP;
    iso_en   = sel & op.iso_wr   & HAS_TOP;
    mem_en   = sel & op.mem_wr;
    rst_en   = sel & op.rst_wr;
    clk_en   = sel & op.clk_wr   & HAS_CLK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= RST_TOP;
      iso_q   <= RST_TOP;
      mem_q   <= RST_MEM;
      rst_q   <= 1'b0;
      clk_q   <= RST_CLK;
    end else begin
      if (sleep_en) sleep_q <= op.val;
      if (iso_en)   iso_q   <= op.val;
      if (mem_en)   mem_q   <= {MEM_W{op.val}};
      if (rst_en)   rst_q   <= op.val;
      if (clk_en)   clk_q   <= op.val;
    end
  end

  assign sleep_o  = sleep_q;
  assign iso_o    = iso_q;
  assign rst_o    = rst_q;
  assign clk_en_o = clk_q;
  assign mem_o    = mem_q;
  assign off_o    = HAS_TOP ? sleep_q : (&mem_q);

endmodule

// File: rtl/pwr_switch_seq.sv
module pwr_switch_seq
  import pwr_seq_pkg::*;
#(
  parameter int               N_DOM      = 3,
  parameter int               MEM_W      = 4,
  parameter int               CYC_PER_US = 200,
  parameter int               SHORT_US   = 20,
  parameter int               LONG_US    = 20000,
  parameter logic [N_DOM-1:0] HAS_TOP    = 3'b011,
  parameter logic [N_DOM-1:0] HAS_CLK    = 3'b001,
  parameter logic [N_DOM-1:0] BOOT_ON    = 3'b001,
  localparam int              DOM_W      = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic [DOM_W-1:0]       req_dom_i,
  input  logic                   req_on_i,
  input  logic                   shutdown_i,
  output logic                   busy_o,
  output logic [N_DOM-1:0]       off_o,
  output logic [N_DOM-1:0]       sleep_o,
  output logic [N_DOM-1:0]       iso_o,
  output logic [N_DOM*MEM_W-1:0] mem_pd_o,
  output logic [N_DOM-1:0]       rst_o,
  output logic [N_DOM-1:0]       clk_en_o
);

  localparam int IDX_W     = $clog2(N_DOM + 1);
  localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int LONG_CYC  = LONG_US * CYC_PER_US;
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  // Reset: asserted asynchronously, released through two flops
  logic rs_meta_q, rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n      <= rs_meta_q;
    end
  end

  seq_state_e       state_q, state_d;
  logic [DOM_W-1:0] dom_q, dom_d;
  logic             on_q, on_d;
  logic             sd_q, sd_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  dom_op_t          op;
  logic             ld;
  logic [CW-1:0]    ld_val;
  logic             wait_done;
  logic [N_DOM-1:0] off_w;
  logic             req_ok, req_same;

  pwr_wait_ctr #(.CW(CW)) u_wait (
    .clk      (clk),
    .rst_n    (rs_n),
    .load     (ld),
    .load_val (ld_val),
    .zero     (wait_done)
  );

  always_comb begin
    req_ok   = req_i && (32'(req_dom_i) < N_DOM);
    req_same = req_on_i ? ~off_w[req_dom_i] : (off_w[req_dom_i] | BOOT_ON[req_dom_i]);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    dom_d   = dom_q;
    on_d    = on_q;
    sd_d    = sd_q;
    idx_d   = idx_q;
    op      = '0;
    ld      = 1'b0;
    ld_val  = CW'(SHORT_CYC - 1);
    case (state_q)
      ST_IDLE: begin
        if (shutdown_i) begin
          sd_d    = 1'b1;
          idx_d   = '0;
          state_d = ST_SCAN;
        end else if (req_ok) begin
          dom_d   = req_dom_i;
          on_d    = req_on_i;
          state_d = req_same ? ST_FIN : ST_TOP;
        end
      end
      ST_SCAN: begin
        if (idx_q == IDX_W'(N_DOM)) begin
          sd_d    = 1'b0;
          state_d = ST_IDLE;
        end else if (HAS_TOP[idx_q] && !off_w[idx_q]) begin
          dom_d   = DOM_W'(idx_q);
          on_d    = 1'b0;
          state_d = ST_TOP;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_TOP: begin
        op.sleep_wr = 1'b1;
        op.val      = ~on_q;
        ld          = 1'b1;
        state_d     = ST_WMEM;
      end
      ST_WMEM: begin
        if (wait_done) begin
          op.mem_wr = 1'b1;
          op.val    = ~on_q;
          ld        = 1'b1;
          state_d   = ST_WGATE;
        end
      end
      ST_WGATE: begin
        if (wait_done) begin
          if (on_q) begin
            op.rst_wr = 1'b1;
            op.val    = 1'b1;
            state_d   = ST_ISOCLR;
          end else begin
            op.iso_wr = 1'b1;
            op.val    = 1'b1;
            if (HAS_CLK[dom_q]) begin
              ld      = 1'b1;
              ld_val  = CW'(LONG_CYC - 1);
              state_d = ST_WCLK;
            end else begin
              state_d = ST_FIN;
            end
          end
        end
      end
      ST_WCLK: begin
        if (wait_done) begin
          op.clk_wr = 1'b1;
          op.val    = 1'b0;
          state_d   = ST_FIN;
        end
      end
      ST_ISOCLR: begin
        op.iso_wr = 1'b1;
        op.val    = 1'b0;
        state_d   = ST_RSTREL;
      end
      ST_RSTREL: begin
        op.rst_wr = 1'b1;
        op.val    = 1'b0;
        state_d   = ST_CLKON;
      end
      ST_CLKON: begin
        op.clk_wr = 1'b1;
        op.val    = 1'b1;
        state_d   = ST_FIN;
      end
      ST_FIN: begin
        if (sd_q) begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_SCAN;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      state_q <= ST_IDLE;
      dom_q   <= '0;
      on_q    <= 1'b0;
      sd_q    <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      dom_q   <= dom_d;
      on_q    <= on_d;
      sd_q    <= sd_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign off_o  = off_w;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    pwr_dom_slice #(
      .MEM_W   (MEM_W),
      .HAS_TOP (HAS_TOP[d]),
      .HAS_CLK (HAS_CLK[d]),
      .BOOT_ON (BOOT_ON[d])
    ) u_slice (
      .clk      (clk),
      .rst_n    (rs_n),
      .sel      (dom_q == DOM_W'(d)),
      .op       (op),
      .sleep_o  (sleep_o[d]),
      .iso_o    (iso_o[d]),
      .rst_o    (rst_o[d]),
      .clk_en_o (clk_en_o[d]),
      .off_o    (off_w[d]),
      .mem_o    (mem_pd_o[d*MEM_W +: MEM_W])
    );

    AST_ISO_AFTER_MEM: assert property (@(posedge clk) disable iff (!rs_n)
      $rose(iso_o[d]) |-> (sleep_o[d] && (&mem_pd_o[d*MEM_W +: MEM_W]))); // R2

    AST_ISO_REL_IN_RST: assert property (@(posedge clk) disable iff (!rs_n)
      $fell(iso_o[d]) |-> rst_o[d]); // R3

    AST_CLK_ON_CLEAN: assert property (@(posedge clk) disable iff (!rs_n)
      $rose(clk_en_o[d]) |-> (!iso_o[d] && !rst_o[d] && !sleep_o[d])); // R3
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rs_n)
    !busy_o |=> ($stable(sleep_o) && $stable(iso_o) && $stable(mem_pd_o)
                 && $stable(rst_o) && $stable(clk_en_o))); // R6

endmodule

// File: tb/sim_pwr_switch_seq.sv
`timescale 1ns/1ps
module sim_pwr_switch_seq;

  localparam int S = 4;
  localparam int L = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  req_dom_i = '0;
  logic        req_on_i = 1'b0;
  logic        shutdown_i = 1'b0;
  logic        busy_o;
  logic [2:0]  off_o, sleep_o, iso_o, rst_o, clk_en_o;
  logic [11:0] mem_pd_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pwr_switch_seq #(
    .N_DOM(3), .MEM_W(4), .CYC_PER_US(1), .SHORT_US(S), .LONG_US(L),
    .HAS_TOP(3'b011), .HAS_CLK(3'b001), .BOOT_ON(3'b001)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_dom_i(req_dom_i),
    .req_on_i(req_on_i), .shutdown_i(shutdown_i), .busy_o(busy_o),
    .off_o(off_o), .sleep_o(sleep_o), .iso_o(iso_o), .mem_pd_o(mem_pd_o),
    .rst_o(rst_o), .clk_en_o(clk_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Leaves the bench at the falling edge after the accepting edge k
  task automatic issue(input logic [1:0] dom, input logic on);
    req_i = 1'b1; req_dom_i = dom; req_on_i = on;
    tick(1);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) tick(1);
  endtask

  task automatic t_reset();
    chk("R1 sleep", 32'(sleep_o), 32'h2);
    chk("R1 iso", 32'(iso_o), 32'h2);
    chk("R1 mem", 32'(mem_pd_o), 32'hFF0);
    chk("R1 clk_en", 32'(clk_en_o), 32'h1);
    chk("R1 rst", 32'(rst_o), 32'h0);
    chk("R1 busy", 32'(busy_o), 32'h0);
    chk("R5 off status at reset", 32'(off_o), 32'h6);
  endtask

  task automatic t_aon_off();
    issue(2'd0, 1'b0);
    chk("R8 busy one cycle", 32'(busy_o), 32'h1);
    tick(1);
    chk("R8 busy dropped", 32'(busy_o), 32'h0);
    tick(3 * S);
    chk("R8 domain0 still awake", 32'({sleep_o[0], clk_en_o[0]}), 32'h1);
    chk("R8 domain0 mem", 32'(mem_pd_o[3:0]), 32'h0);
  endtask

  task automatic t_redundant();
    issue(2'd1, 1'b0);
    chk("R7 busy one cycle", 32'(busy_o), 32'h1);
    tick(1);
    chk("R7 busy dropped", 32'(busy_o), 32'h0);
    tick(3 * S);
    chk("R7 outputs unchanged", 32'({sleep_o, iso_o, rst_o, clk_en_o}), 32'h481);
    chk("R7 mem unchanged", 32'(mem_pd_o), 32'hFF0);
  endtask

  task automatic t_on_dom1(input logic ign_on, input logic [3:0] exp_mem2);
    issue(2'd1, 1'b1);
    chk("R6 busy at acceptance", 32'(busy_o), 32'h1);
    tick(1);                                           // k+1
    chk("R3 sleep1 cleared", 32'(sleep_o[1]), 32'h0);
    chk("R5 off1 follows sleep", 32'(off_o[1]), 32'h0);
    chk("R3 mem1 not yet", 32'(mem_pd_o[7:4]), 32'hF);
    req_i = 1'b1; req_dom_i = 2'd2; req_on_i = ign_on;  // request while busy
    tick(1);                                           // k+2
    req_i = 1'b0;
    tick(S - 2);                                       // k+S
    chk("R3 mem1 held one edge early", 32'(mem_pd_o[7:4]), 32'hF);
    tick(1);                                           // k+1+S
    chk("R3 mem1 cleared", 32'(mem_pd_o[7:4]), 32'h0);
    tick(S - 1);                                       // k+2S
    chk("R3 rst1 not yet", 32'(rst_o[1]), 32'h0);
    tick(1);                                           // k+1+2S
    chk("R3 rst1 asserted, iso held", 32'({rst_o[1], iso_o[1]}), 32'h3);
    tick(1);                                           // k+2+2S
    chk("R3 iso1 released in reset", 32'({rst_o[1], iso_o[1]}), 32'h2);
    tick(1);                                           // k+3+2S
    chk("R3 rst1 released", 32'(rst_o[1]), 32'h0);
    tick(1);                                           // k+4+2S
    chk("R6 busy through last step", 32'(busy_o), 32'h1);
    tick(1);
    chk("R6 busy cleared", 32'(busy_o), 32'h0);
    chk("R6 request while busy ignored", 32'(mem_pd_o[11:8]), 32'(exp_mem2));
  endtask

  task automatic t_off_dom1();
    issue(2'd1, 1'b0);
    tick(1);
    chk("R2 sleep1 set", 32'(sleep_o[1]), 32'h1);
    chk("R2 mem1 not yet", 32'(mem_pd_o[7:4]), 32'h0);
    tick(S);
    chk("R2 mem1 set", 32'(mem_pd_o[7:4]), 32'hF);
    chk("R2 iso1 not yet", 32'(iso_o[1]), 32'h0);
    tick(S - 1);
    chk("R2 iso1 held one edge early", 32'(iso_o[1]), 32'h0);
    tick(1);
    chk("R2 iso1 set", 32'(iso_o[1]), 32'h1);
    chk("R2 busy at last step", 32'(busy_o), 32'h1);
    tick(1);
    chk("R2 busy cleared", 32'(busy_o), 32'h0);
    chk("R5 off1", 32'(off_o[1]), 32'h1);
  endtask

  task automatic t_memonly();
    issue(2'd2, 1'b1);
    tick(S);
    chk("R4 mem2 not yet", 32'(mem_pd_o[11:8]), 32'hF);
    chk("R5 memonly off", 32'(off_o[2]), 32'h1);
    tick(1);
    chk("R4 mem2 cleared", 32'(mem_pd_o[11:8]), 32'h0);
    chk("R5 memonly on", 32'(off_o[2]), 32'h0);
    tick(S);
    chk("R4 rst2 pulse", 32'(rst_o[2]), 32'h1);
    wait_idle();
    chk("R4 sleep2/iso2 untouched", 32'({sleep_o[2], iso_o[2], rst_o[2]}), 32'h0);
  endtask

  task automatic t_shutdown();
    chk("R9 all on before", 32'(off_o), 32'h0);
    shutdown_i = 1'b1;
    tick(1);
    shutdown_i = 1'b0;
    tick(1 + 2 * S + L);                                // k+1+2S+L
    chk("R9 dom0 asleep, clock still on", 32'({sleep_o[0], iso_o[0], clk_en_o[0]}), 32'h7);
    chk("R9 dom1 not started", 32'(sleep_o[1]), 32'h0);
    tick(1);                                           // k+2+2S+L
    chk("R2 dom0 clock gated after long wait", 32'(clk_en_o[0]), 32'h0);
    tick(2);                                           // k+4+2S+L
    chk("R9 dom1 waits for dom0", 32'(sleep_o[1]), 32'h0);
    tick(1);                                           // k+5+2S+L
    chk("R9 dom1 sleep set in order", 32'(sleep_o[1]), 32'h1);
    wait_idle();
    chk("R9 final status", 32'(off_o), 32'h3);
    chk("R9 memonly left alone", 32'(mem_pd_o[11:8]), 32'h0);
    chk("R9 iso final", 32'(iso_o), 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_aon_off();
    t_redundant();
    t_on_dom1(1'b1, 4'hF);
    t_off_dom1();
    t_memonly();
    t_on_dom1(1'b0, 4'h0);
    t_shutdown();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule